// File: doc/BRIEF.md
# SPI Slave Transaction Status Register

This block sits beside an SPI slave byte shifter and keeps a one-byte summary of the last completed transaction. While chip select is low it watches the byte strobes coming from the shifter. Each strobe is tagged as a command, address, write-data or read-data byte. From these strobes it collects separate parities for the bytes written and the bytes read, a count of data bytes, and a flag that records whether the target behind the interface refused a data transfer.

When chip select returns high, the block combines these results with the flash-mode and flash-ready indications into an 8-bit status byte. It holds that byte until the end of the next transaction. A host can therefore read the status of a finished transaction while it runs the next one. The bit shifter and the memory behind it are outside the block.

Top module: `spi_txn_status`

## Requirements
- R1: Status bit 7 is set when at least one data byte strobe occurred with `tgt_ready` low during the transaction. A data byte is a strobe with kind 2'b10 (write data) or 2'b11 (read data). A strobe with kind 2'b00 (command) or 2'b01 (address) never sets bit 7.
- R2: Status bit 6 is the even parity (XOR of all bits) of every read-data byte (kind 2'b11) in the transaction. It is 0 when no read-data byte occurred.
- R3: Status bit 5 is the even parity of every byte with kind 2'b00, 2'b01 or 2'b10 in the transaction. This includes the command and address bytes.
- R4: Status bits 4:2 hold the number of data bytes (kinds 2'b10 and 2'b11) modulo 8, when the transaction carried four or more bytes in total.
- R5: When the transaction carried one, two or three bytes of any kind, bits 4:2 read 3'b111. A transaction with no bytes at all reports 3'b000.
- R6: Status bit 1 equals `flash_mode_in` AND `test_pin_in`, both sampled at the end of the transaction. It is 0 whenever the test pin is low.
- R7: Status bit 0 equals `flash_ready_in` sampled at the end of the transaction, gated by status bit 1.
- R8: After a synchronous reset, `stat_q` reads 8'h00.
- R9: `stat_q` changes only in the clock cycle after the first rising clock edge at which `cs_n` is sampled high following a low period. It stays constant throughout a transaction in progress.
- R10: Byte strobes presented while `cs_n` is high have no effect on the current or the next status.
- R11: Parities, counts and the error flag start from zero in every transaction. Nothing carries over from a previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| byte_vld | input | 1 | One-cycle strobe: a byte was moved by the shifter |
| byte_kind | input | 2 | 00 command, 01 address, 10 write data, 11 read data |
| byte_val | input | 8 | Value of the strobed byte |
| tgt_ready | input | 1 | Target ready to perform the requested data transfer |
| test_pin_in | input | 1 | Test pin level |
| flash_mode_in | input | 1 | Flash programming mode is active |
| flash_ready_in | input | 1 | Flash can accept another write instruction |
| stat_q | output | 8 | Latched status of the previous transaction |

## Verification
The bench uses the default parameters: 8-bit bytes, a 3-bit count field and a short-instruction limit of three bytes. Random transactions of zero to eleven bytes therefore cross the boundary between three and four total bytes. They also wrap the data count past eight, so both the fixed 3'b111 code and the modulo count are exercised. With the narrow byte width, parity flips quickly under random values, which separates the read parity from the write parity.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_CNT_W = 3;

  typedef enum logic [1:0] {
    BK_CMD   = 2'b00,
    BK_ADDR  = 2'b01,
    BK_WDATA = 2'b10,
    BK_RDATA = 2'b11
  } byte_kind_e;

  typedef struct packed {
    logic                  rdy_err;
    logic                  rd_par;
    logic                  wr_par;
    logic [STAT_CNT_W-1:0] cnt;
    logic                  flash_mode;
    logic                  flash_rdy;
  } stat_t;

  function automatic logic is_data_kind(input logic [1:0] k);
    return (k == BK_WDATA) || (k == BK_RDATA);
  endfunction
endpackage

// File: rtl/spi_stat_csedge.sv
module spi_stat_csedge (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  output logic txn_end
);
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_n;
  end

  assign txn_end = cs_n & ~cs_q;
endmodule

// File: rtl/spi_stat_par.sv
module spi_stat_par #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  output logic              par_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) par_q <= 1'b0;
    else if (en)    par_q <= par_q ^ (^data);
  end
endmodule

// File: rtl/spi_stat_cnt.sv
module spi_stat_cnt #(
  parameter int CNT_W     = 3,
  parameter int SHORT_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             any_en,
  input  logic             data_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             is_short
);
  localparam int TOT_W   = $clog2(SHORT_MAX + 2);
  localparam int TOT_SAT = SHORT_MAX + 1;

  logic [TOT_W-1:0] tot_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      tot_q <= '0;
    end else begin
      if (data_en) cnt_q <= cnt_q + 1'b1;
      if (any_en && (tot_q != TOT_W'(TOT_SAT))) tot_q <= tot_q + 1'b1;
    end
  end

  assign is_short = (tot_q != '0) && (tot_q <= TOT_W'(SHORT_MAX));
endmodule

// File: rtl/spi_txn_status.sv
module spi_txn_status #(
  parameter int DATA_W    = 8,
  parameter int SHORT_MAX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_vld,
  input  logic [1:0]        byte_kind,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              tgt_ready,
  input  logic              test_pin_in,
  input  logic              flash_mode_in,
  input  logic              flash_ready_in,
  output logic [7:0]        stat_q
);
  import spi_stat_pkg::*;

  localparam int N_PAR = 2;
  localparam logic [3:0] KIND_MASK [N_PAR] = '{4'b0111, 4'b1000};

  logic       txn_end;
  logic       take;
  logic [N_PAR-1:0] par;
  logic [STAT_CNT_W-1:0] dcnt;
  logic       is_short;
  logic       err_q;
  stat_t      nxt;

  spi_stat_csedge u_edge (
    .clk(clk), .rst(rst), .cs_n(cs_n), .txn_end(txn_end)
  );

  assign take = byte_vld & ~cs_n;

  for (genvar g = 0; g < N_PAR; g++) begin : g_par
    spi_stat_par #(.DATA_W(DATA_W)) u_par (
      .clk(clk), .rst(rst), .clr(txn_end),
      .en(take & KIND_MASK[g][byte_kind]),
      .data(byte_val), .par_q(par[g])
    );
  end

  spi_stat_cnt #(.CNT_W(STAT_CNT_W), .SHORT_MAX(SHORT_MAX)) u_cnt (
    .clk(clk), .rst(rst), .clr(txn_end),
    .any_en(take), .data_en(take & is_data_kind(byte_kind)),
    .cnt_q(dcnt), .is_short(is_short)
  );

  always_ff @(posedge clk) begin
    if (rst || txn_end) err_q <= 1'b0;
    else if (take && is_data_kind(byte_kind) && !tgt_ready) err_q <= 1'b1;
  end

  always_comb begin
    nxt.rdy_err    = err_q;
    nxt.rd_par     = par[1];
    nxt.wr_par     = par[0];
    nxt.cnt        = is_short ? '1 : dcnt;
    nxt.flash_mode = flash_mode_in & test_pin_in;
    nxt.flash_rdy  = flash_ready_in & nxt.flash_mode;
  end

  always_ff @(posedge clk) begin
    if (rst)          stat_q <= 8'h00;
    else if (txn_end) stat_q <= nxt;
  end
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       byte_vld,
  input logic [1:0] byte_kind,
  input logic       tgt_ready,
  input logic       test_pin_in,
  input logic [7:0] stat_q
);
  logic csq;
  logic seen_err;
  logic end_now;

  assign end_now = cs_n & ~csq;

  always_ff @(posedge clk) begin
    if (rst) begin
      csq      <= 1'b1;
      seen_err <= 1'b0;
    end else begin
      csq <= cs_n;
      if (end_now) seen_err <= 1'b0;
      else if (byte_vld && !cs_n && byte_kind[1] && !tgt_ready) seen_err <= 1'b1;
    end
  end

  // R8
  a_r8_reset_zero: assert property (@(posedge clk) rst |=> stat_q == 8'h00);
  // R9
  a_r9_hold_midtxn: assert property (@(posedge clk) disable iff (rst)
    !end_now |=> $stable(stat_q));
  // R6
  a_r6_test_low: assert property (@(posedge clk) disable iff (rst)
    (end_now && !test_pin_in) |=> !stat_q[1]);
  // R7
  a_r7_ready_gated: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] |-> stat_q[1]);
  // R1
  a_r1_err_flag: assert property (@(posedge clk) disable iff (rst)
    end_now |=> (stat_q[7] == $past(seen_err)));
endmodule

bind spi_txn_status spi_stat_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld),
  .byte_kind(byte_kind), .tgt_ready(tgt_ready),
  .test_pin_in(test_pin_in), .stat_q(stat_q)
);

// File: tb/spi_txn_status_tb_top.sv
`timescale 1ns/1ps
module spi_txn_status_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       byte_vld = 1'b0;
  logic [1:0] byte_kind = 2'b00;
  logic [7:0] byte_val = 8'h00;
  logic       tgt_ready = 1'b1;
  logic       test_pin_in = 1'b0;
  logic       flash_mode_in = 1'b0;
  logic       flash_ready_in = 1'b0;
  logic [7:0] stat_q;

  spi_txn_status dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld),
    .byte_kind(byte_kind), .byte_val(byte_val), .tgt_ready(tgt_ready),
    .test_pin_in(test_pin_in), .flash_mode_in(flash_mode_in),
    .flash_ready_in(flash_ready_in), .stat_q(stat_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] last_exp = 8'h00;
  logic e_err, e_rp, e_wp;
  int   e_dcnt, e_tot;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic tp, input logic fm, input logic fr);
    logic [2:0] c;
    logic fmb;
    c   = (e_tot >= 1 && e_tot <= 3) ? 3'b111 : 3'(e_dcnt % 8);
    fmb = tp & fm;
    return {e_err, e_rp, e_wp, c, fmb, fr & fmb};
  endfunction

  task automatic start_txn();
    @(negedge clk);
    cs_n = 1'b0;
    e_err = 0; e_rp = 0; e_wp = 0; e_dcnt = 0; e_tot = 0;
  endtask

  task automatic put_byte(input logic [1:0] k, input logic [7:0] v, input logic rdy);
    @(negedge clk);
    byte_vld = 1'b1; byte_kind = k; byte_val = v; tgt_ready = rdy;
    e_tot++;
    if (k[1]) begin
      e_dcnt++;
      if (!rdy) e_err = 1;
    end
    if (k == 2'b11) e_rp ^= ^v;
    else            e_wp ^= ^v;
    @(negedge clk);
    byte_vld = 1'b0; tgt_ready = 1'b1;
    check("R9 stable during transaction", stat_q, last_exp);
  endtask

  task automatic end_txn(input string req, input logic tp, input logic fm, input logic fr);
    @(negedge clk);
    cs_n = 1'b1; test_pin_in = tp; flash_mode_in = fm; flash_ready_in = fr;
    last_exp = model(tp, fm, fr);
    @(negedge clk);
    check(req, stat_q, last_exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset value", stat_q, 8'h00);

    // R5 short instruction, R3 write parity
    start_txn(); put_byte(2'b00, 8'h03, 1); put_byte(2'b01, 8'h10, 1); put_byte(2'b10, 8'h01, 1);
    end_txn("R5 three-byte short", 0, 0, 0);
    // R4 four bytes, R2 read parity
    start_txn(); put_byte(2'b00, 8'h0B, 1); put_byte(2'b01, 8'h00, 1); put_byte(2'b01, 8'h20, 1);
    put_byte(2'b11, 8'h07, 1);
    end_txn("R4 four-byte count one", 1, 0, 1);
    // R4 wrap past eight data bytes
    start_txn(); put_byte(2'b00, 8'h02, 1);
    for (int i = 0; i < 9; i++) put_byte(2'b10, 8'(i * 37), 1);
    end_txn("R4 count wraps modulo 8", 0, 1, 1);
    // R5 empty transaction
    start_txn(); end_txn("R5 zero-byte transaction", 0, 0, 0);
    // R1 ready error on data byte, not on command
    start_txn(); put_byte(2'b00, 8'h01, 0); put_byte(2'b01, 8'h02, 0); put_byte(2'b01, 8'h03, 1);
    put_byte(2'b11, 8'hA5, 0);
    end_txn("R1 ready error", 1, 1, 0);
    start_txn(); put_byte(2'b00, 8'h01, 0); put_byte(2'b01, 8'h02, 0); put_byte(2'b01, 8'h03, 0);
    put_byte(2'b00, 8'h04, 0);
    end_txn("R1 no error from command/address", 0, 0, 0);
    // R6 R7 flash bits
    start_txn(); put_byte(2'b00, 8'h80, 1); end_txn("R6 test pin low forces zero", 0, 1, 1);
    start_txn(); put_byte(2'b00, 8'h80, 1); end_txn("R7 flash ready reported", 1, 1, 1);
    start_txn(); put_byte(2'b00, 8'h80, 1); end_txn("R7 flash ready gated", 1, 0, 1);
    // R10 strobes while deselected
    @(negedge clk); byte_vld = 1'b1; byte_kind = 2'b11; byte_val = 8'h01; tgt_ready = 1'b0;
    @(negedge clk); byte_vld = 1'b0; tgt_ready = 1'b1;
    @(negedge clk); check("R10 idle strobe ignored", stat_q, last_exp);
    start_txn(); put_byte(2'b00, 8'h00, 1);
    end_txn("R10 R11 next transaction clean", 0, 0, 0);

    // random
    for (int t = 0; t < 80; t++) begin
      int n;
      n = $urandom_range(0, 11);
      start_txn();
      for (int b = 0; b < n; b++)
        put_byte(2'($urandom_range(0, 3)), 8'($urandom), $urandom_range(0, 9) != 0);
      end_txn("R1-R7 random transaction R11", 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule